// File: doc/BRIEF.md
# Register Change/Use Interlock

This block sits at the address-generation stage of an in-order operand pipeline. It decides whether the instruction now generating an operand address depends on a register that the instruction just ahead of it is still updating. If it does, the block works out how many cycles the dependent instruction has to wait. The previous instruction is described by a write flag, the destination register and a producer class. When two instructions issue together, the caller supplies the instruction in the primary pipe as the producer, because that instruction sets the pair's timing. The current instruction is described by its base and index register fields, a use flag for each of them, the index width and the index scale.

The penalty depends on three things: whether the clashing register is used as a base or as an index, how that index is sized and scaled, and the producer class. One producer class covers fast-result operations. These are load-effective-address, move of a long immediate to a register, move-quick, clear of a data register, and the address-register update made by post-increment or pre-decrement addressing. A fast-result producer costs nothing for base use or for a cheap index, but it still costs the full index penalty when the index form is expensive.

A two-state controller loads the computed penalty into a down-counter. It then holds the pipeline for exactly that many cycles and ignores new requests until the counter is empty. The states are `ST_IDLE` and `ST_STALL`. The transition `IDLE→STALL` happens on a valid request whose penalty is nonzero. The transition `STALL→STALL` happens while the count is above one, and the count drops by one each cycle. The transition `STALL→IDLE` happens when the count steps from one to zero. Any other case stays in `IDLE`.

Top module: `cu_interlock`

## Requirements
- R1: A synchronous active-high `rst` forces `stall_cnt` to 0 and `hold` low, including in the middle of a stall.
- R2: With producer class `00` (ordinary) or the reserved class `11`, which is treated as ordinary, a written register used as the base costs 2 stall cycles.
- R3: With an ordinary producer, a written register used as a long index (`idx_long`=1) with scale ×1 (`idx_scale`=00) or ×4 (`idx_scale`=10) costs 2 stall cycles.
- R4: With an ordinary or fast-result producer, a written register used as an index with scale ×2 (`01`) or ×8 (`11`), or used as a word index (`idx_long`=0), costs 3 stall cycles.
- R5: With a fast-result producer (class `01`), base use costs 0 cycles, and long-index use at scale ×1 or ×4 also costs 0 cycles.
- R6: With a memory-loaded address producer (class `10`), any base or index use of the written register costs exactly 1 cycle.
- R7: When both the base and the index match the written register, the stall equals the larger of the two penalties.
- R8: No stall results when `prod_wr` is low, when `cons_valid` is low, when neither used field names the written register, or when the matching field's use flag is low.
- R9: A valid request in idle loads `stall_cnt` with the penalty on the next clock edge. `hold` is high exactly while `stall_cnt` is nonzero.
- R10: While `hold` is high, `stall_cnt` drops by one per cycle, and every request input is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| prod_wr | input | 1 | Previous (primary-pipe) instruction writes a register |
| prod_reg | input | 4 | Register written by the previous instruction (0-7 data, 8-15 address) |
| prod_cls | input | 2 | Producer class: 00 ordinary, 01 fast-result, 10 memory-loaded address, 11 as ordinary |
| cons_valid | input | 1 | Current instruction requests hazard evaluation |
| base_use | input | 1 | Current address calculation uses a base register |
| base_reg | input | 4 | Base register number |
| idx_use | input | 1 | Current address calculation uses an index register |
| idx_reg | input | 4 | Index register number |
| idx_long | input | 1 | Index width: 1 long, 0 word |
| idx_scale | input | 2 | Index scale: 00 ×1, 01 ×2, 10 ×4, 11 ×8 |
| stall_cnt | output | 2 | Remaining stall cycles |
| hold | output | 1 | Stall the consumer this cycle |

## Verification
The assertions assume that the request inputs are free of X and stable across the clock edge that samples them. They also assume that `rst` is held high at time zero, so every clocked check starts from a known idle state. The bench changes inputs only on the falling edge and raises `cons_valid` for a single sampling edge per scenario. The exception is the ignore scenario, which keeps a conflicting request active during a stall on purpose to show that it has no effect.

// File: rtl/cu_pkg.sv
package cu_pkg;

    typedef enum logic [1:0] {
        PC_ALU     = 2'b00,
        PC_FAST    = 2'b01,
        PC_MEMADDR = 2'b10,
        PC_RSVD    = 2'b11
    } prod_cls_e;

    typedef enum logic [1:0] {
        SC_X1 = 2'b00,
        SC_X2 = 2'b01,
        SC_X4 = 2'b10,
        SC_X8 = 2'b11
    } idx_scale_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_STALL = 1'b1
    } fsm_state_e;

endpackage

// File: rtl/cu_hazard_match.sv
module cu_hazard_match #(
    parameter int REG_W = 4
) (
    input  logic             prod_wr,
    input  logic [REG_W-1:0] prod_reg,
    input  logic             base_use,
    input  logic [REG_W-1:0] base_reg,
    input  logic             idx_use,
    input  logic [REG_W-1:0] idx_reg,
    output logic             base_hit,
    output logic             idx_hit
);

    // A hit needs a real write and an actual use of the matching field.
    always_comb begin
        base_hit = prod_wr && base_use && (base_reg == prod_reg);
        idx_hit  = prod_wr && idx_use  && (idx_reg  == prod_reg);
    end

endmodule

// File: rtl/cu_penalty.sv
module cu_penalty
    import cu_pkg::*;
#(
    parameter int CNT_W          = 2,
    parameter int PEN_BASE_ALU   = 2,
    parameter int PEN_IDX_CHEAP  = 2,
    parameter int PEN_IDX_COSTLY = 3,
    parameter int PEN_MEMADDR    = 1
) (
    input  logic [1:0]       cls,
    input  logic             base_hit,
    input  logic             idx_hit,
    input  logic             idx_long,
    input  logic [1:0]       idx_scale,
    output logic [CNT_W-1:0] pen
);

    localparam logic [CNT_W-1:0] P_ZERO   = '0;
    localparam logic [CNT_W-1:0] P_BASE   = CNT_W'(PEN_BASE_ALU);
    localparam logic [CNT_W-1:0] P_CHEAP  = CNT_W'(PEN_IDX_CHEAP);
    localparam logic [CNT_W-1:0] P_COSTLY = CNT_W'(PEN_IDX_COSTLY);
    localparam logic [CNT_W-1:0] P_MEM    = CNT_W'(PEN_MEMADDR);

    prod_cls_e        cls_e;
    logic             cheap_idx;
    logic [CNT_W-1:0] base_pen;
    logic [CNT_W-1:0] idx_pen;

    always_comb begin
        cls_e     = prod_cls_e'(cls);
        // Long index at x1 or x4 takes the short path.
        cheap_idx = idx_long && ((idx_scale == SC_X1) || (idx_scale == SC_X4));
    end

    always_comb begin
        base_pen = P_ZERO;
        if (base_hit) begin
            unique case (cls_e)
                PC_FAST:    base_pen = P_ZERO;
                PC_MEMADDR: base_pen = P_MEM;
                default:    base_pen = P_BASE;
            endcase
        end
    end

    always_comb begin
        idx_pen = P_ZERO;
        if (idx_hit) begin
            unique case (cls_e)
                PC_FAST:    idx_pen = cheap_idx ? P_ZERO  : P_COSTLY;
                PC_MEMADDR: idx_pen = P_MEM;
                default:    idx_pen = cheap_idx ? P_CHEAP : P_COSTLY;
            endcase
        end
    end

    always_comb begin
        pen = (base_pen > idx_pen) ? base_pen : idx_pen;
    end

    always_comb begin
        AST_MAX_COVERS_BASE: assert (pen >= base_pen) else $error("base penalty lost"); // R7
        AST_MAX_COVERS_IDX: assert (pen >= idx_pen) else $error("index penalty lost"); // R7
    end

endmodule

// File: rtl/cu_stall_fsm.sv
module cu_stall_fsm
    import cu_pkg::*;
#(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             eval_en,
    input  logic [CNT_W-1:0] pen,
    output logic [CNT_W-1:0] stall_cnt,
    output logic             hold
);

    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    fsm_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // State register and counter.
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Next state: requests are only looked at in idle.
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (eval_en && (pen != '0)) begin
                    state_d = ST_STALL;
                    cnt_d   = pen;
                end
            end
            ST_STALL: begin
                cnt_d = cnt_q - CNT_ONE;
                if (cnt_q == CNT_ONE) begin
                    state_d = ST_IDLE;
                end
            end
            default: begin
                state_d = ST_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    // Outputs.
    always_comb begin
        hold      = (state_q == ST_STALL);
        stall_cnt = cnt_q;
    end

    AST_HOLD_TRACKS_CNT: assert property (@(posedge clk) disable iff (rst)
        hold == (stall_cnt != '0)) else $error("hold/count mismatch"); // R9

    AST_LOAD_FROM_PEN: assert property (@(posedge clk) disable iff (rst)
        (!hold && eval_en) |=> (stall_cnt == $past(pen))) else $error("penalty not loaded"); // R9

    AST_CNT_STEPS_DOWN: assert property (@(posedge clk) disable iff (rst)
        (stall_cnt != '0) |=> (stall_cnt == $past(stall_cnt) - CNT_ONE)) else $error("count did not step"); // R10

endmodule

// File: rtl/cu_interlock.sv
module cu_interlock
    import cu_pkg::*;
#(
    parameter int REG_W          = 4,
    parameter int CNT_W          = 2,
    parameter int PEN_BASE_ALU   = 2,
    parameter int PEN_IDX_CHEAP  = 2,
    parameter int PEN_IDX_COSTLY = 3,
    parameter int PEN_MEMADDR    = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             prod_wr,
    input  logic [REG_W-1:0] prod_reg,
    input  logic [1:0]       prod_cls,
    input  logic             cons_valid,
    input  logic             base_use,
    input  logic [REG_W-1:0] base_reg,
    input  logic             idx_use,
    input  logic [REG_W-1:0] idx_reg,
    input  logic             idx_long,
    input  logic [1:0]       idx_scale,
    output logic [CNT_W-1:0] stall_cnt,
    output logic             hold
);

    logic             base_hit;
    logic             idx_hit;
    logic [CNT_W-1:0] pen;

    cu_hazard_match #(.REG_W(REG_W)) u_match (
        .prod_wr  (prod_wr),
        .prod_reg (prod_reg),
        .base_use (base_use),
        .base_reg (base_reg),
        .idx_use  (idx_use),
        .idx_reg  (idx_reg),
        .base_hit (base_hit),
        .idx_hit  (idx_hit)
    );

    cu_penalty #(
        .CNT_W          (CNT_W),
        .PEN_BASE_ALU   (PEN_BASE_ALU),
        .PEN_IDX_CHEAP  (PEN_IDX_CHEAP),
        .PEN_IDX_COSTLY (PEN_IDX_COSTLY),
        .PEN_MEMADDR    (PEN_MEMADDR)
    ) u_pen (
        .cls       (prod_cls),
        .base_hit  (base_hit),
        .idx_hit   (idx_hit),
        .idx_long  (idx_long),
        .idx_scale (idx_scale),
        .pen       (pen)
    );

    cu_stall_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .eval_en   (cons_valid),
        .pen       (pen),
        .stall_cnt (stall_cnt),
        .hold      (hold)
    );

    AST_NOWRITE_NOSTALL: assert property (@(posedge clk) disable iff (rst)
        (!hold && cons_valid && !prod_wr) |=> !hold) else $error("stall without a write"); // R8

    AST_MEMADDR_ONE: assert property (@(posedge clk) disable iff (rst)
        (!hold && cons_valid && prod_wr && (prod_cls == PC_MEMADDR) &&
         ((base_use && (base_reg == prod_reg)) || (idx_use && (idx_reg == prod_reg))))
        |=> (stall_cnt == CNT_W'(1))) else $error("memory-loaded producer not one cycle"); // R6

    AST_RESET_CLEARS: assert property (@(posedge clk)
        $past(rst) |-> (!hold && (stall_cnt == '0))) else $error("reset did not clear"); // R1

endmodule

// File: tb/cu_interlock_tb.sv
`timescale 1ns/1ps
module cu_interlock_tb;

    logic       clk = 1'b0;
    logic       rst;
    logic       prod_wr;
    logic [3:0] prod_reg;
    logic [1:0] prod_cls;
    logic       cons_valid;
    logic       base_use;
    logic [3:0] base_reg;
    logic       idx_use;
    logic [3:0] idx_reg;
    logic       idx_long;
    logic [1:0] idx_scale;
    logic [1:0] stall_cnt;
    logic       hold;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  finished = 1'b0;

    always #2.5 clk = ~clk;

    cu_interlock u_dut (
        .clk        (clk),
        .rst        (rst),
        .prod_wr    (prod_wr),
        .prod_reg   (prod_reg),
        .prod_cls   (prod_cls),
        .cons_valid (cons_valid),
        .base_use   (base_use),
        .base_reg   (base_reg),
        .idx_use    (idx_use),
        .idx_reg    (idx_reg),
        .idx_long   (idx_long),
        .idx_scale  (idx_scale),
        .stall_cnt  (stall_cnt),
        .hold       (hold)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic set_req(input bit wr, input int preg, input int cls,
                           input bit bu, input int breg, input bit iu, input int ireg,
                           input bit il, input int sc);
        prod_wr   = wr;
        prod_reg  = 4'(preg);
        prod_cls  = 2'(cls);
        base_use  = bu;
        base_reg  = 4'(breg);
        idx_use   = iu;
        idx_reg   = 4'(ireg);
        idx_long  = il;
        idx_scale = 2'(sc);
    endtask

    // Pulse a request, then follow the countdown to idle.
    task automatic eval_expect(input string req, input int exp);
        @(negedge clk);
        cons_valid = 1'b1;
        @(negedge clk);
        cons_valid = 1'b0;
        check(req, "loaded count", int'(stall_cnt), exp);
        check(req, "hold after load", int'(hold), int'(exp != 0));
        for (int k = exp - 1; k >= 0; k--) begin
            @(negedge clk);
            check(req, "countdown", int'(stall_cnt), k);
            check(req, "hold in countdown", int'(hold), int'(k != 0));
        end
    endtask

    task automatic t_reset();
        rst = 1'b1;
        cons_valid = 1'b0;
        set_req(0, 0, 0, 0, 0, 0, 0, 1, 0);
        repeat (3) @(negedge clk);
        check("R1", "count in reset", int'(stall_cnt), 0);
        check("R1", "hold in reset", int'(hold), 0);
        rst = 1'b0;
    endtask

    task automatic t_base_alu();
        set_req(1, 9, 0, 1, 9, 0, 0, 1, 0);
        eval_expect("R2", 2);               // R2 ordinary base
        set_req(1, 3, 3, 1, 3, 0, 0, 1, 0);
        eval_expect("R2", 2);               // R2 reserved class acts as ordinary
    endtask

    task automatic t_idx_cheap();
        set_req(1, 4, 0, 0, 0, 1, 4, 1, 0);
        eval_expect("R3", 2);               // R3 long x1
        set_req(1, 12, 0, 0, 0, 1, 12, 1, 2);
        eval_expect("R3", 2);               // R3 long x4
    endtask

    task automatic t_idx_costly();
        set_req(1, 5, 0, 0, 0, 1, 5, 1, 1);
        eval_expect("R4", 3);               // R4 long x2
        set_req(1, 5, 0, 0, 0, 1, 5, 1, 3);
        eval_expect("R4", 3);               // R4 long x8
        set_req(1, 5, 0, 0, 0, 1, 5, 0, 0);
        eval_expect("R4", 3);               // R4 word index
        set_req(1, 2, 1, 0, 0, 1, 2, 0, 2);
        eval_expect("R4", 3);               // R4 fast producer, word index
        set_req(1, 2, 1, 0, 0, 1, 2, 1, 3);
        eval_expect("R4", 3);               // R4 fast producer, long x8
    endtask

    task automatic t_fast();
        set_req(1, 10, 1, 1, 10, 0, 0, 1, 0);
        eval_expect("R5", 0);               // R5 fast base
        set_req(1, 10, 1, 0, 0, 1, 10, 1, 2);
        eval_expect("R5", 0);               // R5 fast long x4
    endtask

    task automatic t_memaddr();
        set_req(1, 11, 2, 1, 11, 0, 0, 1, 0);
        eval_expect("R6", 1);               // R6 base
        set_req(1, 11, 2, 0, 0, 1, 11, 0, 3);
        eval_expect("R6", 1);               // R6 word index
    endtask

    task automatic t_both();
        set_req(1, 7, 0, 1, 7, 1, 7, 1, 1);
        eval_expect("R7", 3);               // R7 base 2 vs index 3
        set_req(1, 7, 0, 1, 7, 1, 7, 1, 0);
        eval_expect("R7", 2);               // R7 both 2
        set_req(1, 7, 1, 1, 7, 1, 7, 0, 0);
        eval_expect("R7", 3);               // R7 fast base 0 vs index 3
    endtask

    task automatic t_none();
        set_req(0, 6, 0, 1, 6, 1, 6, 0, 3);
        eval_expect("R8", 0);               // R8 no write
        set_req(1, 6, 0, 1, 8, 1, 9, 0, 3);
        eval_expect("R8", 0);               // R8 no register match
        set_req(1, 6, 0, 0, 6, 0, 6, 0, 3);
        eval_expect("R8", 0);               // R8 use flags low
        set_req(1, 6, 0, 1, 6, 1, 6, 0, 3);
        @(negedge clk);                     // R8 request not valid
        cons_valid = 1'b0;
        @(negedge clk);
        check("R8", "no request count", int'(stall_cnt), 0);
        check("R8", "no request hold", int'(hold), 0);
    endtask

    task automatic t_ignore();
        set_req(1, 9, 0, 1, 9, 0, 0, 1, 0);
        @(negedge clk);
        cons_valid = 1'b1;
        @(negedge clk);
        check("R10", "first load", int'(stall_cnt), 2);
        set_req(1, 4, 0, 0, 0, 1, 4, 0, 0);  // costly hazard kept active
        @(negedge clk);
        check("R10", "request ignored", int'(stall_cnt), 1);
        cons_valid = 1'b0;
        @(negedge clk);
        check("R10", "returns idle", int'(stall_cnt), 0);
        check("R10", "hold dropped", int'(hold), 0);
    endtask

    task automatic t_reset_mid();
        set_req(1, 1, 0, 0, 0, 1, 1, 0, 0);
        @(negedge clk);
        cons_valid = 1'b1;
        @(negedge clk);
        cons_valid = 1'b0;
        check("R1", "before reset", int'(stall_cnt), 3);
        rst = 1'b1;
        @(negedge clk);
        check("R1", "count after mid reset", int'(stall_cnt), 0);
        check("R1", "hold after mid reset", int'(hold), 0);
        rst = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    endtask

    initial begin
        t_reset();
        t_base_alu();
        t_idx_cheap();
        t_idx_costly();
        t_fast();
        t_memaddr();
        t_both();
        t_none();
        t_ignore();
        t_reset_mid();
        repeat (2) @(negedge clk);
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

endmodule